// File: doc/BRIEF.md
# Timed Output Event Scheduler

This block keeps a small table of commands that must happen at set moments of a free-running 16-bit timer. Each command has a target time and an action. Every clock cycle, every occupied slot compares its time with the timer value on `timer_i`. A slot whose time matches carries out its action, and the slot becomes free. No processor has to watch the timer.

An action can drive one of six output lines high or low, or set one of four sticky software flags. It can also pulse a strobe that restarts a second timer, pulse a strobe that starts a conversion, or pulse an interrupt. The second timer and the converter sit outside this block and see only the strobes. A producer writes commands through a one-cycle write port. While every slot is occupied, `full_o` is high and further writes are dropped.

Top module: `evt_sched`

## Requirements
- R1: The table holds up to 8 pending commands. A write (`cmd_valid_i` high while `full_o` is low) is stored at the next clock edge in the lowest-numbered free slot, and every stored command fires later.
- R2: `full_o` is high exactly when all 8 slots are occupied. A write presented while `full_o` is high is dropped and never has any effect.
- R3: A stored command fires in the cycle where `timer_i` equals its time exactly, and not before. Its effect appears on the outputs after the next rising clock edge. Its slot is freed at that same edge, so the command never fires again.
- R4: Kind 0 (line action), with an index from 0 to 5, drives `lines_o[index]` to the level bit `cmd_lvl_i`. The line holds that level until another line action changes it.
- R5: Kind 1 (flag action), with an index from 0 to 3, sets `flags_o[index]`. A flag stays set until the matching bit of `flag_clr_i` is high at a clock edge. A set and a clear of the same flag in the same cycle leave the flag set.
- R6: Kind 2 pulses `tmr2_rst_o`, and kind 3 pulses `conv_start_o`. Each pulse is high for the one cycle after the firing edge.
- R7: Kind 4 pulses `irq_o` for the one cycle after the firing edge.
- R8: Any number of commands can fire in the same cycle. All their effects appear together after the same edge.
- R9: Two commands may fire in the same cycle and drive the same line to opposite levels. In that case the command in the lower-numbered slot decides the level.
- R10: Some commands fire with no effect. These are a line action with an index of 6 or 7, a flag action with an index of 4 to 7, and any kind from 5 to 7. Such a command changes no output, but its slot is still freed.
- R11: After reset all slots are free, and `lines_o`, `flags_o`, the strobes, `irq_o` and `full_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Write a command this cycle |
| cmd_time_i | input | 16 | Timer value at which the command fires |
| cmd_kind_i | input | 3 | Action kind: 0 line, 1 flag, 2 second-timer reset, 3 conversion start, 4 interrupt |
| cmd_idx_i | input | 3 | Line or flag index |
| cmd_lvl_i | input | 1 | Level for a line action |
| full_o | output | 1 | All slots occupied |
| timer_i | input | 16 | Running timer value |
| flag_clr_i | input | 4 | Clear strobes for the software flags |
| lines_o | output | 6 | Output lines |
| flags_o | output | 4 | Software flags |
| tmr2_rst_o | output | 1 | Second-timer reset strobe |
| conv_start_o | output | 1 | Conversion start strobe |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench fills all eight slots and then offers a ninth write. A design that accepted it would later raise a line that was never commanded. The bench also puts the timer on a time just before a target and then back on a fired target. Comparing with magnitude, or not freeing a slot, would give an early or a repeated interrupt. Two commands drive the same line to opposite levels in both slot orders, which catches a reversed priority. Other commands carry out-of-range indices and unused kinds, and would corrupt a line or a flag if decoded loosely. A flag set in the same cycle as its clear catches a design where the clear wins.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;
  localparam int unsigned KIND_W = 3;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [KIND_W-1:0] {
    ACT_LINE  = 3'd0,
    ACT_FLAG  = 3'd1,
    ACT_T2RST = 3'd2,
    ACT_CONV  = 3'd3,
    ACT_IRQ   = 3'd4
  } act_kind_e;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [IDX_W-1:0]  idx;
    logic              lvl;
  } act_t;
endpackage

// File: rtl/evt_slot_table.sv
module evt_slot_table
  import evt_sched_pkg::*;
#(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [TIME_W-1:0] wr_time_i,
  input  act_t              wr_act_i,
  input  logic [TIME_W-1:0] timer_i,
  output logic              full_o,
  output logic [SLOTS-1:0]  valid_o,
  output logic [SLOTS-1:0]  fire_o,
  output act_t              act_o [SLOTS]
);
  logic [SLOTS-1:0]  valid_q;
  logic [TIME_W-1:0] time_q [SLOTS];
  act_t              act_q  [SLOTS];
  logic [SLOTS-1:0]  free_w, grant_w;
  logic              wr_ok;

  assign full_o  = &valid_q;
  assign wr_ok   = wr_i & ~full_o;
  assign free_w  = ~valid_q;
  // isolate lowest set bit of the free mask
  assign grant_w = free_w & (~free_w + SLOTS'(1));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign fire_o[s] = valid_q[s] && (time_q[s] == timer_i);
    assign act_o[s]  = act_q[s];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[s] <= 1'b0;
        time_q[s]  <= '0;
        act_q[s]   <= '0;
      end else if (wr_ok && grant_w[s]) begin
        valid_q[s] <= 1'b1;
        time_q[s]  <= wr_time_i;
        act_q[s]   <= wr_act_i;
      end else if (fire_o[s]) begin
        valid_q[s] <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/evt_action_merge.sv
module evt_action_merge
  import evt_sched_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned LINES = 6,
  parameter int unsigned FLAGS = 4
) (
  input  logic [SLOTS-1:0] fire_i,
  input  act_t             act_i [SLOTS],
  input  logic [LINES-1:0] lines_q_i,
  output logic [LINES-1:0] lines_d_o,
  output logic [FLAGS-1:0] flag_set_o,
  output logic             t2rst_o,
  output logic             conv_o,
  output logic             irq_o
);
  always_comb begin
    lines_d_o  = lines_q_i;
    flag_set_o = '0;
    t2rst_o    = 1'b0;
    conv_o     = 1'b0;
    irq_o      = 1'b0;
    // walk high to low so the lowest firing slot writes a line last
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (fire_i[i]) begin
        case (act_i[i].kind)
          ACT_LINE: begin
            for (int j = 0; j < LINES; j++)
              if (act_i[i].idx == IDX_W'(j)) lines_d_o[j] = act_i[i].lvl;
          end
          ACT_FLAG: begin
            for (int j = 0; j < FLAGS; j++)
              if (act_i[i].idx == IDX_W'(j)) flag_set_o[j] = 1'b1;
          end
          ACT_T2RST: t2rst_o = 1'b1;
          ACT_CONV:  conv_o  = 1'b1;
          ACT_IRQ:   irq_o   = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/evt_sched.sv
module evt_sched
  import evt_sched_pkg::*;
#(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned TIME_W = 16,
  parameter int unsigned LINES  = 6,
  parameter int unsigned FLAGS  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [TIME_W-1:0]     cmd_time_i,
  input  logic [KIND_W-1:0]     cmd_kind_i,
  input  logic [IDX_W-1:0]      cmd_idx_i,
  input  logic                  cmd_lvl_i,
  output logic                  full_o,
  input  logic [TIME_W-1:0]     timer_i,
  input  logic [FLAGS-1:0]      flag_clr_i,
  output logic [LINES-1:0]      lines_o,
  output logic [FLAGS-1:0]      flags_o,
  output logic                  tmr2_rst_o,
  output logic                  conv_start_o,
  output logic                  irq_o
);
  act_t             wr_act;
  logic [SLOTS-1:0] valid_w, fire_w;
  act_t             act_w [SLOTS];
  logic [LINES-1:0] lines_d, lines_q;
  logic [FLAGS-1:0] flag_set, flags_q;
  logic             t2rst_d, conv_d, irq_d;
  logic             t2rst_q, conv_q, irq_q;

  assign wr_act = '{kind: cmd_kind_i, idx: cmd_idx_i, lvl: cmd_lvl_i};

  evt_slot_table #(.SLOTS(SLOTS), .TIME_W(TIME_W)) i_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cmd_valid_i),
    .wr_time_i (cmd_time_i),
    .wr_act_i  (wr_act),
    .timer_i   (timer_i),
    .full_o    (full_o),
    .valid_o   (valid_w),
    .fire_o    (fire_w),
    .act_o     (act_w)
  );

  evt_action_merge #(.SLOTS(SLOTS), .LINES(LINES), .FLAGS(FLAGS)) i_merge (
    .fire_i     (fire_w),
    .act_i      (act_w),
    .lines_q_i  (lines_q),
    .lines_d_o  (lines_d),
    .flag_set_o (flag_set),
    .t2rst_o    (t2rst_d),
    .conv_o     (conv_d),
    .irq_o      (irq_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q <= '0;
      flags_q <= '0;
      t2rst_q <= 1'b0;
      conv_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      lines_q <= lines_d;
      flags_q <= (flags_q & ~flag_clr_i) | flag_set;
      t2rst_q <= t2rst_d;
      conv_q  <= conv_d;
      irq_q   <= irq_d;
    end
  end

  assign lines_o      = lines_q;
  assign flags_o      = flags_q;
  assign tmr2_rst_o   = t2rst_q;
  assign conv_start_o = conv_q;
  assign irq_o        = irq_q;
endmodule

// File: rtl/evt_sched_chk.sv
module evt_sched_chk #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned LINES = 6,
  parameter int unsigned FLAGS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             full_o,
  input logic [FLAGS-1:0] flag_clr_i,
  input logic [LINES-1:0] lines_o,
  input logic [FLAGS-1:0] flags_o,
  input logic             tmr2_rst_o,
  input logic             conv_start_o,
  input logic             irq_o,
  input logic [SLOTS-1:0] valid_w,
  input logic [SLOTS-1:0] fire_w
);
  a_r1_write_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !full_o && fire_w == '0)
      |=> $countones(valid_w) == $past($countones(valid_w)) + 1);

  a_r2_full_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && full_o && fire_w == '0) |=> full_o);

  a_r3_slot_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_w != '0) |=> (valid_w & $past(fire_w)) == '0);

  a_r4_lines_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fire_w) == '0) |-> $stable(lines_o));

  a_r5_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flags_o) & ~flags_o & ~$past(flag_clr_i)) == '0);

  // R6 and R7: every pulse is caused by a firing slot
  a_r6_strobe_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr2_rst_o || conv_start_o || irq_o) |-> $past(fire_w) != '0);
endmodule

bind evt_sched evt_sched_chk #(.SLOTS(SLOTS), .LINES(LINES), .FLAGS(FLAGS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .full_o       (full_o),
  .flag_clr_i   (flag_clr_i),
  .lines_o      (lines_o),
  .flags_o      (flags_o),
  .tmr2_rst_o   (tmr2_rst_o),
  .conv_start_o (conv_start_o),
  .irq_o        (irq_o),
  .valid_w      (valid_w),
  .fire_w       (fire_w)
);

// File: tb/test_evt_sched.sv
module test_evt_sched;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] IDLE_T = 16'h8000;
  localparam int NVEC = 10;
  // {kind, idx, lvl, time, exp_lines, exp_flags, exp_strobes{irq,conv,t2rst}}
  localparam logic [35:0] VEC [NVEC] = '{
    {3'd0, 3'd2, 1'b1, 16'h0010, 6'h04, 4'h0, 3'b000},
    {3'd0, 3'd5, 1'b1, 16'h1234, 6'h24, 4'h0, 3'b000},
    {3'd1, 3'd3, 1'b0, 16'hFFFF, 6'h24, 4'h8, 3'b000},
    {3'd2, 3'd0, 1'b0, 16'h0000, 6'h24, 4'h8, 3'b001},
    {3'd3, 3'd0, 1'b0, 16'h00AB, 6'h24, 4'h8, 3'b010},
    {3'd4, 3'd0, 1'b0, 16'h7FFF, 6'h24, 4'h8, 3'b100},
    {3'd0, 3'd2, 1'b0, 16'h0200, 6'h20, 4'h8, 3'b000},
    {3'd0, 3'd6, 1'b1, 16'h0300, 6'h20, 4'h8, 3'b000},
    {3'd6, 3'd1, 1'b1, 16'h0400, 6'h20, 4'h8, 3'b000},
    {3'd1, 3'd0, 1'b0, 16'h0500, 6'h20, 4'h9, 3'b000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [15:0] cmd_time_i = '0;
  logic [2:0]  cmd_kind_i = '0;
  logic [2:0]  cmd_idx_i = '0;
  logic        cmd_lvl_i = 1'b0;
  logic        full_o;
  logic [15:0] timer_i = IDLE_T;
  logic [3:0]  flag_clr_i = '0;
  logic [5:0]  lines_o;
  logic [3:0]  flags_o;
  logic        tmr2_rst_o, conv_start_o, irq_o;

  int errors = 0;
  int checks = 0;
  logic [5:0] lines_exp;
  logic [3:0] flags_exp;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  evt_sched i_evt_sched (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] k, input logic [2:0] ix, input logic lv, input logic [15:0] t);
    cmd_kind_i = k; cmd_idx_i = ix; cmd_lvl_i = lv; cmd_time_i = t; cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic fire(input logic [15:0] t);
    timer_i = t;
    @(negedge clk_i);
    timer_i = IDLE_T;
  endtask

  function automatic string tag_of(input logic [2:0] k, input logic [2:0] ix);
    case (k)
      3'd0: return (ix > 3'd5) ? "R10 line index out of range" : "R4 line";
      3'd1: return "R5 flag set";
      3'd2: return "R6 timer2 reset";
      3'd3: return "R6 conversion start";
      3'd4: return "R7 interrupt";
      default: return "R10 unused kind";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R11 reset lines", 32'(lines_o), 0);
    chk("R11 reset flags", 32'(flags_o), 0);
    chk("R11 reset strobes", 32'({irq_o, conv_start_o, tmr2_rst_o}), 0);
    chk("R11 reset full", 32'(full_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table-driven single commands
    for (int v = 0; v < NVEC; v++) begin
      string tg;
      tg = tag_of(VEC[v][35:33], VEC[v][32:30]);
      wr(VEC[v][35:33], VEC[v][32:30], VEC[v][29], VEC[v][28:13]);
      fire(VEC[v][28:13]);
      chk({tg, " lines"}, 32'(lines_o), 32'(VEC[v][12:7]));
      chk({tg, " flags"}, 32'(flags_o), 32'(VEC[v][6:3]));
      chk({tg, " strobes"}, 32'({irq_o, conv_start_o, tmr2_rst_o}), 32'(VEC[v][2:0]));
    end
    @(negedge clk_i);
    chk("R6 strobes last one cycle", 32'({irq_o, conv_start_o, tmr2_rst_o}), 0);
    lines_exp = 6'h20;
    flags_exp = 4'h9;

    // R1/R2: fill all slots, refuse a ninth
    for (int s = 0; s < 8; s++) wr(3'd4, 3'd0, 1'b0, 16'h1000 + 16'(s));
    chk("R2 full after eight writes", 32'(full_o), 1);
    wr(3'd0, 3'd0, 1'b1, 16'h2000);
    fire(16'h1000);
    chk("R3 first entry fires", 32'(irq_o), 1);
    chk("R1 slot freed clears full", 32'(full_o), 0);
    fire(16'h1000);
    chk("R3 no second firing", 32'(irq_o), 0);
    fire(16'h2000);
    chk("R2 refused write has no effect", 32'(lines_o), 32'(lines_exp));
    for (int s = 1; s < 8; s++) begin
      fire(16'h1000 + 16'(s));
      chk("R1 every stored entry fires", 32'(irq_o), 1);
    end

    // R3: exact match only
    wr(3'd4, 3'd0, 1'b0, 16'h0050);
    fire(16'h004F);
    chk("R3 no firing before target", 32'(irq_o), 0);
    fire(16'h0050);
    chk("R3 fires at target", 32'(irq_o), 1);

    // R8: several entries fire together
    wr(3'd0, 3'd1, 1'b1, 16'h0600);
    wr(3'd1, 3'd1, 1'b0, 16'h0600);
    wr(3'd3, 3'd0, 1'b0, 16'h0600);
    fire(16'h0600);
    lines_exp |= 6'h02; flags_exp |= 4'h2;
    chk("R8 joint line", 32'(lines_o), 32'(lines_exp));
    chk("R8 joint flag", 32'(flags_o), 32'(flags_exp));
    chk("R8 joint conversion strobe", 32'(conv_start_o), 1);

    // R9: lower slot wins a line conflict, both orders
    wr(3'd0, 3'd4, 1'b1, 16'h0700);
    wr(3'd0, 3'd4, 1'b0, 16'h0700);
    fire(16'h0700);
    lines_exp[4] = 1'b1;
    chk("R9 slot0 high beats slot1 low", 32'(lines_o), 32'(lines_exp));
    wr(3'd0, 3'd4, 1'b0, 16'h0800);
    wr(3'd0, 3'd4, 1'b1, 16'h0800);
    fire(16'h0800);
    lines_exp[4] = 1'b0;
    chk("R9 slot0 low beats slot1 high", 32'(lines_o), 32'(lines_exp));

    // R5: clear, and set beating clear
    flag_clr_i = 4'b0001;
    @(negedge clk_i);
    flag_clr_i = '0;
    flags_exp[0] = 1'b0;
    chk("R5 flag cleared", 32'(flags_o), 32'(flags_exp));
    wr(3'd1, 3'd2, 1'b0, 16'h0900);
    flag_clr_i = 4'b0100;
    fire(16'h0900);
    flag_clr_i = '0;
    flags_exp[2] = 1'b1;
    chk("R5 set wins over clear", 32'(flags_o), 32'(flags_exp));

    // R10: out-of-range flag index
    wr(3'd1, 3'd5, 1'b0, 16'h0A00);
    fire(16'h0A00);
    chk("R10 flag index out of range", 32'(flags_o), 32'(flags_exp));
    chk("R10 all slots free afterwards", 32'(full_o), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule